// File: doc/BRIEF.md
# Change-of-State Interrupt Unit with Capture Latch

This block watches a 16-bit digital input port and drives a single interrupt request line. Each input bit passes through a two-stage synchroniser clocked by the block's sampling clock. Every synchronised sample is compared with the one before it, and the enable mask decides which channels may raise the request. When the request fires, the synchronised input word of that cycle is copied into a capture latch that the host can read. A clear input, pulsed by the host once it has serviced the interrupt, drops the request and zeroes the latch.

A mode input picks one of two request sources, and only one is in force at a time. In change-of-state mode a transition in either direction on any enabled channel raises the request. In low-channel mode only a rising edge on channel 0 or channel 1 raises it. While a request is pending the unit ignores further input activity. Inputs are sampled once per clock, so a pulse shorter than one sample period may be missed. The bus interface, the interrupt controller and any input filtering sit outside this block.

Top module: `cos_irq_unit`

## Requirements
- R1: With mode = 0 (change-of-state) and all channels enabled, a rising or falling transition on any input bit asserts irq_req on the third rising clock edge after the input changes. The first two edges pass through the synchroniser.
- R2: A channel whose chan_en bit is 0 never raises irq_req, whatever its transitions.
- R3: On the edge where irq_req asserts, latch_word takes the synchronised input word of that cycle. While irq_req is low, latch_word reads 0x0000.
- R4: A cycle with irq_clear = 1 drops irq_req and sets latch_word to 0x0000 on that clock edge. No request is taken in that cycle. Detection resumes on the following cycle.
- R5: While irq_req is pending, input transitions neither change latch_word nor raise a second request. Such a transition is not recalled after the clear.
- R6: With mode = 1 (low-channel), only a rising edge on an enabled bit 0 or bit 1 raises irq_req. Falling edges on those bits have no effect, and neither do transitions on bits 2 to 15.
- R7: While rst_n = 0 at a clock edge (synchronous, active-low), irq_req and latch_word are cleared. After reset the first real sample becomes the comparison reference, so a nonzero input level at reset raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Asynchronous digital input channels |
| chan_en | input | 16 | Per-channel interrupt enable mask |
| mode | input | 1 | 0: change-of-state on all channels; 1: rising edge on channel 0 or 1 |
| irq_clear | input | 1 | Host acknowledge; drops the request and zeroes the latch |
| irq_req | output | 1 | Shared interrupt request |
| latch_word | output | 16 | Input word captured when the request fired |

## Verification
The bench starts with a nonzero input level held through reset. A unit that compared the first sample against a zeroed reference would raise a spurious request at once. It times each request to the third edge after the input change, checks both transition directions, and changes the inputs while a request is pending. A design that kept updating the latch would overwrite the captured word, and one that queued the missed edge would fire again after the clear. It also toggles masked high channels, and in low-channel mode it drives falling edges and edges on upper bits. A wrong mask or a wrong edge polarity would show up there as a request that should not happen.

// File: rtl/cos_irq_pkg.sv
// Package: shared types for the change-of-state interrupt unit.
// Assumes: a single request source mode is active at any time.
package cos_irq_pkg;
    typedef enum logic {
        MODE_COS  = 1'b0,
        MODE_LOW  = 1'b1
    } irq_mode_e;
endpackage

// File: rtl/cos_sync.sv
// Module: multi-stage synchroniser for a word of asynchronous inputs.
// Assumes: each bit is independent (no word coherence across bits is needed).
module cos_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage: capture the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_async;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Later stages: shift the sample one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/cos_edge_detect.sv
// Module: compares each synchronised sample with the previous one and flags
// a qualifying transition according to the selected mode.
// Assumes: sample is already synchronised. Detection is held off until the
// synchroniser holds real data and the reference has been loaded from it.
module cos_edge_detect
    import cos_irq_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int STAGES  = 2,
    parameter int LOW_CH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample,
    input  logic [WIDTH-1:0] chan_en,
    input  irq_mode_e        mode,
    output logic             hit
);
    localparam int FILL_MAX = STAGES + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [WIDTH-1:0]  prev;
    logic [FILL_W-1:0] fill;
    logic              armed;
    logic [WIDTH-1:0]  any_chg;
    logic [LOW_CH-1:0] low_rise;

    // Previous-sample register, loaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sample;
    end

    // Pipeline fill counter: saturates once the reference holds a real sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                       fill <= '0;
        else if (fill != FILL_W'(FILL_MAX)) fill <= fill + 1'b1;
    end

    assign armed = (fill == FILL_W'(FILL_MAX));

    // Transition vectors for both modes, masked by the enables.
    always_comb begin
        any_chg  = (sample ^ prev) & chan_en;
        low_rise = sample[LOW_CH-1:0] & ~prev[LOW_CH-1:0] & chan_en[LOW_CH-1:0];
    end

    // Select the active source.
    always_comb begin
        hit = 1'b0;
        if (armed) begin
            if (mode == MODE_COS) hit = |any_chg;
            else                  hit = |low_rise;
        end
    end

    // R2: a flagged transition implies at least one enabled channel.
    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (chan_en != '0));

    // R7: no transition is flagged before the reference holds real data.
    a_r7_no_early_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !hit);
endmodule

// File: rtl/cos_irq_latch.sv
// Module: request flop and capture latch with host clear.
// Assumes: irq_clear takes priority over a new transition in the same cycle.
module cos_irq_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [WIDTH-1:0] sample,
    input  logic             irq_clear,
    output logic             irq_req,
    output logic [WIDTH-1:0] latch_word
);
    // Request and latch: set on the first transition, frozen while pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req    <= 1'b0;
            latch_word <= '0;
        end else if (irq_clear) begin
            irq_req    <= 1'b0;
            latch_word <= '0;
        end else if (!irq_req && hit) begin
            irq_req    <= 1'b1;
            latch_word <= sample;
        end
    end

    // R4: a clear empties the request and the latch on the next cycle.
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> (!irq_req && latch_word == '0));

    // R5: a pending request keeps its latch until cleared.
    a_r5_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clear) |=> (irq_req && $stable(latch_word)));

    // R3: the latch reads zero whenever no request is pending.
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (latch_word == '0));

    // R1: a request only rises after a flagged transition.
    a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(hit));
endmodule

// File: rtl/cos_irq_unit.sv
// Module: top of the change-of-state interrupt unit.
// Assumes: clk is the sampling clock; din is asynchronous to it; the host
// pulses irq_clear after reading latch_word.
module cos_irq_unit
    import cos_irq_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2,
    parameter int LOW_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] chan_en,
    input  logic             mode,
    input  logic             irq_clear,
    output logic             irq_req,
    output logic [WIDTH-1:0] latch_word
);
    logic [WIDTH-1:0] sample;
    logic             hit;
    irq_mode_e        mode_e;

    assign mode_e = irq_mode_e'(mode);

    cos_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (din),
        .d_sync  (sample)
    );

    cos_edge_detect #(.WIDTH(WIDTH), .STAGES(STAGES), .LOW_CH(LOW_CH)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .chan_en (chan_en),
        .mode    (mode_e),
        .hit     (hit)
    );

    cos_irq_latch #(.WIDTH(WIDTH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .sample     (sample),
        .irq_clear  (irq_clear),
        .irq_req    (irq_req),
        .latch_word (latch_word)
    );
endmodule

// File: tb/cos_irq_unit_test.sv
// Bench: scoreboard. The driver pushes expected latch words and change
// cycles into queues; the monitor pops them on each rising request.
module cos_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = 16'h0000;
    logic [15:0] chan_en = 16'hFFFF;
    logic        mode = 1'b0;
    logic        irq_clear = 1'b0;
    logic        irq_req;
    logic [15:0] latch_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic        irq_prev = 1'b0;
    logic [15:0] exp_q [$];
    int          exp_cyc_q [$];
    string       tag_q [$];

    cos_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .din(din), .chan_en(chan_en),
        .mode(mode), .irq_clear(irq_clear), .irq_req(irq_req),
        .latch_word(latch_word)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: change din; optionally expect a request with this word.
    task automatic drive(input logic [15:0] w, input bit expect_irq, input string tag);
        @(negedge clk);
        din = w;
        if (expect_irq) begin
            exp_q.push_back(w);
            exp_cyc_q.push_back(cyc + 3);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear(input string tag);
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(irq_req == 1'b0, tag, irq_req, 0);
        check(latch_word == 16'h0, tag, latch_word, 0);
    endtask

    // Monitor: on each rising request compare latch and timing with the queue.
    always @(negedge clk) begin
        if (rst_n && irq_req && !irq_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected request R2/R5/R6/R7", latch_word, 0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic int ec = exp_cyc_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(latch_word == e, {t, " latch R3"}, latch_word, e);
                check(cyc == ec, {t, " timing R1"}, cyc, ec);
            end
        end
        irq_prev <= irq_req;
    end

    initial begin
        din = 16'h321A;
        idle(4);
        check(irq_req == 1'b0, "R7 reset irq", irq_req, 0);
        check(latch_word == 16'h0, "R7 reset latch", latch_word, 0);
        rst_n = 1'b1;
        idle(8);
        check(irq_req == 1'b0, "R7 no spurious request", irq_req, 0);

        // R1: mixed rise and fall, all channels enabled.
        drive(16'hC76A, 1'b1, "R1 change");
        idle(2);
        check(irq_req == 1'b0, "R1 not before third edge", irq_req, 0);
        idle(2);
        check(irq_req == 1'b1, "R1 request up", irq_req, 1);
        do_clear("R4 clear");

        // R1: pure falling edge on bit 1.
        drive(16'hC768, 1'b1, "R1 fall");
        idle(5);
        // R5: change while pending.
        drive(16'hFFFF, 1'b0, "R5");
        idle(5);
        check(latch_word == 16'hC768, "R5 latch frozen", latch_word, 16'hC768);
        check(irq_req == 1'b1, "R5 still pending", irq_req, 1);
        do_clear("R4 clear2");
        idle(6);
        check(irq_req == 1'b0, "R5 no recall after clear", irq_req, 0);

        // R5: detection resumes after the clear.
        drive(16'h00F0, 1'b1, "R5 resume");
        idle(5);
        do_clear("R4 clear3");

        // R2: masked upper byte.
        chan_en = 16'h00FF;
        drive(16'hFFF0, 1'b0, "R2");
        idle(6);
        check(irq_req == 1'b0, "R2 masked channels ignored", irq_req, 0);
        drive(16'hFFF1, 1'b1, "R2 enabled bit0");
        idle(5);
        do_clear("R4 clear4");

        // R6: low-channel mode.
        chan_en = 16'hFFFF;
        mode = 1'b1;
        idle(2);
        drive(16'hFFD1, 1'b0, "R6");
        idle(6);
        check(irq_req == 1'b0, "R6 upper bit ignored", irq_req, 0);
        drive(16'hFFD0, 1'b0, "R6");
        idle(6);
        check(irq_req == 1'b0, "R6 falling bit0 ignored", irq_req, 0);
        drive(16'hFFD2, 1'b1, "R6 rising bit1");
        idle(5);
        check(irq_req == 1'b1, "R6 request up", irq_req, 1);
        do_clear("R4 clear5");
        chan_en = 16'hFFFE;
        drive(16'hFFD3, 1'b0, "R6");
        idle(6);
        check(irq_req == 1'b0, "R6 disabled bit0 ignored", irq_req, 0);

        check(exp_q.size() == 0, "R1 all expected requests seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end
endmodule